// File: doc/BRIEF.md
# Dual DAC Load and Transfer Front End

This block sits between a byte-wide register bus and a pair of digital-to-analog converters. Each converter channel owns a two-byte input register, assembled from a low-byte write and a high-byte write. A separate output latch holds the code the converter actually sees. A 16-bit write at a channel's low-byte offset loads both bytes in one bus cycle. This is meant for converters narrower than 16 bits: their code is left-justified, and the unused low bits of the latch are forced to zero.

A static strap input picks when the input registers reach the output latches. In individual mode, each high-byte (or 16-bit) write moves that channel's assembled word into its own latch. In transfer mode, writes only fill the input registers. A read of any converter register then moves both channels into their latches on the same clock edge, so both analog outputs change together. A shared range register carries a 2-bit output-range selector for each channel.

Top module: `dual_dac_loader`

## Requirements
- R1: Synchronous reset clears both input registers and both output codes to zero, and sets both range selectors to 2 (0 to 5 V). In the range encoding, 0 means ±5 V, 1 means ±10 V, 2 means 0 to 5 V and 3 means 0 to 10 V.
- R2: A byte write to offset 4+2n stores the byte as channel n's low input byte and does not change any output code.
- R3: In individual mode (xfer_mode = 0), a byte write to offset 5+2n stores the high input byte. On the same edge it loads channel n's code with {written byte, stored low byte}. The other channel's code is unchanged.
- R4: A high-byte write that is not preceded by a fresh low-byte write reuses the low byte already held in the input register.
- R5: In transfer mode (xfer_mode = 1), no write changes either output code.
- R6: In transfer mode, a read of any offset from 4 to 7 loads both output codes from both input registers on the same clock edge.
- R7: In individual mode, reads leave both output codes unchanged.
- R8: A read returns its data on bus_rdata one cycle after the read strobe. Offset 4+2n returns channel n's low input byte, offset 5+2n returns its high input byte, and unmapped offsets return zero.
- R9: Offset 0x0a holds the range selectors, channel 0 in bits 5:4 and channel 1 in bits 7:6. Other bits are ignored on write and read back as zero. Only a write to 0x0a changes a selector.
- R10: With bus_wide = 1 at offset 4+2n, bus_wdata[15:0] loads both input bytes, and in individual mode it also loads the code. When CODE_BITS is below 16, the low 16-CODE_BITS bits of every output code are zero.
- R11: Writes to offsets other than 4 to 7 and 0x0a change no code and no range selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_mode | input | 1 | Strap: 0 individual update, 1 simultaneous transfer |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wide | input | 1 | Write carries 16 bits (honoured at low-byte offsets) |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 8 | Registered read data |
| dac0_code | output | 16 | Channel 0 converter code |
| dac1_code | output | 16 | Channel 1 converter code |
| dac0_range | output | 2 | Channel 0 range selector |
| dac1_range | output | 2 | Channel 1 range selector |

## Verification
A corrupted input register stays hidden in transfer mode until the next converter read. At that point it shows up on both the read data and the committed code, one edge after the read. In individual mode a bad low byte appears in the code on the very next high-byte write, so the bench follows every high-only write with a code check. Cross-channel leakage and commits outside the right mode appear as a code that moves when it should hold. The bench therefore compares every code and selector after each bus operation, in both strap settings, and for a 16-bit and a 12-bit instance.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;

    localparam int CH_COUNT  = 2;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int ADDR_W    = 4;
    localparam int RANGE_W   = 2;
    localparam int RANGE_LSB = 4;

    localparam logic [ADDR_W-1:0] DAC_BASE   = 4'h4;
    localparam logic [ADDR_W-1:0] RANGE_ADDR = 4'hA;

    typedef enum logic [RANGE_W-1:0] {
        RNG_BIP_5   = 2'd0,
        RNG_BIP_10  = 2'd1,
        RNG_UNI_5   = 2'd2,
        RNG_UNI_10  = 2'd3
    } dac_range_e;

    localparam dac_range_e RANGE_AT_RESET = RNG_UNI_5;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } dac_word_t;

    typedef struct packed {
        logic [CH_COUNT-1:0] lo_wr;
        logic [CH_COUNT-1:0] hi_wr;
        logic [CH_COUNT-1:0] wide_wr;
        logic                range_wr;
        logic                dac_rd;
    } bus_strobe_t;

    function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
        return DAC_BASE + ADDR_W'(2 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int ch);
        return DAC_BASE + ADDR_W'(2 * ch + 1);
    endfunction

    function automatic int range_pos(input int ch);
        return RANGE_LSB + RANGE_W * ch;
    endfunction

    function automatic logic [WORD_W-1:0] code_mask(input int bits);
        return {WORD_W{1'b1}} << (WORD_W - bits);
    endfunction

endpackage

// File: rtl/dual_dac_decode.sv
module dual_dac_decode
    import dual_dac_pkg::*;
(
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_strobe_t       strb
);

    logic [CH_COUNT-1:0] lo_hit;
    logic [CH_COUNT-1:0] hi_hit;

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_hit
        assign lo_hit[g] = (bus_addr == lo_addr(g));
        assign hi_hit[g] = (bus_addr == hi_addr(g));
    end

    always_comb begin
        strb          = '0;
        strb.lo_wr    = bus_wr && !bus_wide ? lo_hit : '0;
        strb.wide_wr  = bus_wr &&  bus_wide ? lo_hit : '0;
        strb.hi_wr    = bus_wr ? hi_hit : '0;
        strb.range_wr = bus_wr && (bus_addr == RANGE_ADDR);
        strb.dac_rd   = bus_rd && (|lo_hit || |hi_hit);
    end

endmodule

// File: rtl/dual_dac_chan.sv
module dual_dac_chan
    import dual_dac_pkg::*;
#(
    parameter int CODE_BITS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_mode,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic              wide_wr,
    input  logic              dac_rd,
    input  logic [WORD_W-1:0] wdata,
    output dac_word_t         in_word,
    output logic [WORD_W-1:0] code
);

    localparam logic [WORD_W-1:0] MASK = code_mask(CODE_BITS);

    logic [WORD_W-1:0] direct_word;
    logic              direct_load;

    assign direct_word = wide_wr ? wdata : {wdata[BYTE_W-1:0], in_word.lo};
    assign direct_load = !xfer_mode && (wide_wr || hi_wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_word <= '0;
        end else if (wide_wr) begin
            in_word <= wdata;
        end else begin
            if (lo_wr) in_word.lo <= wdata[BYTE_W-1:0];
            if (hi_wr) in_word.hi <= wdata[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else if (xfer_mode) begin
            if (dac_rd) code <= in_word & MASK;
        end else if (direct_load) begin
            code <= direct_word & MASK;
        end
    end

    p_xfer_hold_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_mode && !dac_rd |=> $stable(code));

    p_indiv_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !xfer_mode && !hi_wr && !wide_wr |=> $stable(code));

    p_reuse_low_r4: assert property (@(posedge clk) disable iff (rst)
        !xfer_mode && hi_wr && !lo_wr && !wide_wr
        |=> code[BYTE_W-1:0] == ($past(in_word.lo) & MASK[BYTE_W-1:0]));

    p_low_bits_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (code & ~MASK) == '0);

endmodule

// File: rtl/dual_dac_range.sv
module dual_dac_range
    import dual_dac_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           range_wr,
    input  logic [BYTE_W-1:0]              wdata,
    output logic [CH_COUNT-1:0][RANGE_W-1:0] rng
);

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst) begin
                rng[g] <= RANGE_AT_RESET;
            end else if (range_wr) begin
                rng[g] <= wdata[range_pos(g) +: RANGE_W];
            end
        end
    end

    p_range_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !range_wr |=> $stable(rng));

    p_range_reset_r1: assert property (@(posedge clk)
        rst |=> (rng[0] == RANGE_AT_RESET) && (rng[CH_COUNT-1] == RANGE_AT_RESET));

endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dual_dac_pkg::*;
#(
    parameter int CODE_BITS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        xfer_mode,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_wide,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic [15:0] dac0_code,
    output logic [15:0] dac1_code,
    output logic [1:0]  dac0_range,
    output logic [1:0]  dac1_range
);

    localparam logic [WORD_W-1:0] MASK = code_mask(CODE_BITS);

    bus_strobe_t                     strb;
    dac_word_t                       in_word [CH_COUNT];
    logic [WORD_W-1:0]               code    [CH_COUNT];
    logic [CH_COUNT-1:0][RANGE_W-1:0] rng;
    logic [BYTE_W-1:0]               rd_next;

    dual_dac_decode u_decode (
        .bus_wr   (bus_wr),
        .bus_wide (bus_wide),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .strb     (strb)
    );

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
        dual_dac_chan #(.CODE_BITS(CODE_BITS)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .xfer_mode (xfer_mode),
            .lo_wr     (strb.lo_wr[g]),
            .hi_wr     (strb.hi_wr[g]),
            .wide_wr   (strb.wide_wr[g]),
            .dac_rd    (strb.dac_rd),
            .wdata     (bus_wdata),
            .in_word   (in_word[g]),
            .code      (code[g])
        );
    end

    dual_dac_range u_range (
        .clk      (clk),
        .rst      (rst),
        .range_wr (strb.range_wr),
        .wdata    (bus_wdata[BYTE_W-1:0]),
        .rng      (rng)
    );

    always_comb begin
        rd_next = '0;
        for (int c = 0; c < CH_COUNT; c++) begin
            if (bus_addr == lo_addr(c)) rd_next = in_word[c].lo;
            if (bus_addr == hi_addr(c)) rd_next = in_word[c].hi;
        end
        if (bus_addr == RANGE_ADDR) begin
            for (int c = 0; c < CH_COUNT; c++) begin
                rd_next[range_pos(c) +: RANGE_W] = rng[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_next;
        end
    end

    assign dac0_code  = code[0];
    assign dac1_code  = code[1];
    assign dac0_range = rng[0];
    assign dac1_range = rng[1];

    p_reset_codes_r1: assert property (@(posedge clk)
        rst |=> (dac0_code == '0) && (dac1_code == '0));

    p_both_commit_r6: assert property (@(posedge clk) disable iff (rst)
        xfer_mode && strb.dac_rd
        |=> (dac0_code == ($past(in_word[0]) & MASK))
         && (dac1_code == ($past(in_word[1]) & MASK)));

    p_other_chan_r3: assert property (@(posedge clk) disable iff (rst)
        !xfer_mode && !strb.hi_wr[1] && !strb.wide_wr[1] |=> $stable(dac1_code));

    p_no_write_commit_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_mode && bus_wr && !bus_rd |=> $stable(dac0_code) && $stable(dac1_code));

    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !bus_rd && (bus_addr < 4'h4 || (bus_addr > 4'h7 && bus_addr != RANGE_ADDR))
        |=> $stable(dac0_code) && $stable(dac1_code)
         && $stable(dac0_range) && $stable(dac1_range));

endmodule

// File: tb/test_dual_dac_loader.sv
module test_dual_dac_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_mode = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_wide = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  rdata16, rdata12;
    logic [15:0] c0_16, c1_16, c0_12, c1_12;
    logic [1:0]  r0_16, r1_16, r0_12, r1_12;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]  m_lo [2];
    logic [7:0]  m_hi [2];
    logic [15:0] m_code [2];
    logic [1:0]  m_rng [2];

    always #5 clk = ~clk;

    dual_dac_loader i_dual_dac_loader (
        .clk(clk), .rst(rst), .xfer_mode(xfer_mode), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wide(bus_wide), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rdata16), .dac0_code(c0_16), .dac1_code(c1_16),
        .dac0_range(r0_16), .dac1_range(r1_16)
    );

    dual_dac_loader #(.CODE_BITS(12)) i_dual_dac_loader_12 (
        .clk(clk), .rst(rst), .xfer_mode(xfer_mode), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wide(bus_wide), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rdata12), .dac0_code(c0_12), .dac1_code(c1_12),
        .dac0_range(r0_12), .dac1_range(r1_12)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " code0"},    c0_16, m_code[0]);
        chk({tag, " code1"},    c1_16, m_code[1]);
        chk({tag, " code0 12b"}, c0_12, m_code[0] & 16'hFFF0);
        chk({tag, " code1 12b"}, c1_12, m_code[1] & 16'hFFF0);
        chk({tag, " range0"},   {14'd0, r0_16}, {14'd0, m_rng[0]});
        chk({tag, " range1"},   {14'd0, r1_16}, {14'd0, m_rng[1]});
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [15:0] d, input logic wide);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wide = wide; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wide = 1'b0;
        for (int c = 0; c < 2; c++) begin
            if (a == 4'(4 + 2 * c)) begin
                if (wide) begin
                    m_lo[c] = d[7:0]; m_hi[c] = d[15:8];
                    if (!xfer_mode) m_code[c] = d;
                end else begin
                    m_lo[c] = d[7:0];
                end
            end
            if (a == 4'(5 + 2 * c)) begin
                m_hi[c] = d[7:0];
                if (!xfer_mode) m_code[c] = {m_hi[c], m_lo[c]};
            end
        end
        if (a == 4'hA) begin
            m_rng[0] = d[5:4];
            m_rng[1] = d[7:6];
        end
    endtask

    task automatic do_rd(input logic [3:0] a, input string tag);
        logic [7:0] exp;
        exp = 8'h00;
        for (int c = 0; c < 2; c++) begin
            if (a == 4'(4 + 2 * c)) exp = m_lo[c];
            if (a == 4'(5 + 2 * c)) exp = m_hi[c];
        end
        if (a == 4'hA) exp = {m_rng[1], m_rng[0], 4'h0};
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        if (xfer_mode && a >= 4'h4 && a <= 4'h7) begin
            for (int c = 0; c < 2; c++) m_code[c] = {m_hi[c], m_lo[c]};
        end
        chk({tag, " rdata"},     {8'd0, rdata16}, {8'd0, exp});
        chk({tag, " rdata 12b"}, {8'd0, rdata12}, {8'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_lo[c] = 0; m_hi[c] = 0; m_code[c] = 0; m_rng[c] = 2'd2;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_state("R1 reset");
        do_rd(4'h4, "R1 reset lo0");
        do_rd(4'hA, "R1 reset range");

        // Individual mode: low byte alone holds outputs, high byte commits one channel
        for (int c = 0; c < 2; c++) begin
            for (int h = 0; h < 256; h += 15) begin
                do_wr(4'(4 + 2 * c), 16'((h * 37 + 11) & 8'hFF), 1'b0);
                chk_state("R2 low byte only");
                do_wr(4'(5 + 2 * c), 16'(h), 1'b0);
                chk_state("R3 high byte commit");
            end
        end

        // High byte alone reuses the held low byte
        do_wr(4'h4, 16'h00A5, 1'b0);
        for (int h = 0; h < 256; h += 51) begin
            do_wr(4'h5, 16'(h), 1'b0);
            chk_state("R4 reuse low");
            do_wr(4'h7, 16'(255 - h), 1'b0);
            chk_state("R4 reuse low ch1");
        end

        // Wide writes and left-justified 12-bit codes
        for (int v = 0; v < 65536; v += 4099) begin
            do_wr(4'h4, 16'(v), 1'b1);
            chk_state("R10 wide ch0");
            do_wr(4'h6, 16'(v ^ 16'h5A5F), 1'b1);
            chk_state("R10 wide ch1");
        end

        // Reads in individual mode do not commit
        do_wr(4'h4, 16'h0033, 1'b0);
        for (int a = 4; a < 8; a++) begin
            do_rd(4'(a), "R8 readback");
            chk_state("R7 read no commit");
        end

        // Range register sweep
        for (int r0 = 0; r0 < 4; r0++) begin
            for (int r1 = 0; r1 < 4; r1++) begin
                do_wr(4'hA, 16'({r1[1:0], r0[1:0], 4'hF} ^ 8'h0C), 1'b0);
                chk_state("R9 range write");
                do_rd(4'hA, "R9 range read");
            end
        end

        // Unmapped writes change nothing
        for (int a = 0; a < 16; a++) begin
            if (a < 4 || (a > 7 && a != 10)) begin
                do_wr(4'(a), 16'hFFFF, 1'b0);
                chk_state("R11 unmapped write");
                do_wr(4'(a), 16'h1234, 1'b1);
                chk_state("R11 unmapped wide");
            end
        end
        do_rd(4'h2, "R8 unmapped read");

        // Transfer mode
        @(negedge clk);
        xfer_mode = 1'b1;
        for (int a = 4; a < 8; a++) begin
            do_wr(4'h4, 16'(a * 19 + 1), 1'b0);
            do_wr(4'h5, 16'(a * 23 + 7), 1'b0);
            chk_state("R5 xfer write hold");
            do_wr(4'h6, 16'(a * 4111), 1'b1);
            do_wr(4'h7, 16'(a * 29), 1'b0);
            chk_state("R5 xfer write hold ch1");
            do_rd(4'(a), "R6 xfer read");
            chk_state("R6 both commit");
        end
        do_wr(4'h5, 16'h00EE, 1'b0);
        do_rd(4'hA, "R6 range read no commit");
        chk_state("R6 non-dac read holds");
        do_rd(4'h7, "R6 final read");
        chk_state("R6 final commit");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule